// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block is a configuration-space search engine. After a start pulse it follows the linked list of extended capabilities that begins at offset 0x100. It uses a single-outstanding dword read port, and it answers two questions about the function behind that port. The first is whether a CXL DVSEC header is present. The second is where the first Data Object Exchange capability sits. Enumeration logic uses it before it sets up the mailbox engine.

The search runs in two passes. In the first pass each node costs three dword reads: the extended header and the two dwords after it. A node is the CXL DVSEC when the vendor field of its second dword matches. Once such a node is found, a second pass starts again at 0x100 and reads only the header of each node until it meets the DOE capability ID. If no DVSEC is found, the second pass is skipped. Two conditions end the walk early with an error: a read error returned by the port, and a chain that is longer than the hop limit.

Top module: `ext_cap_walker`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `rd_req`, `dvsec_found` and `doe_found` are 0, and both offset outputs are 0.
- R2: A `start` pulse while idle begins a walk at offset 0x100 and clears all result outputs. A `start` while `busy` is high has no effect on the reads issued or on the finish time.
- R3: `rd_req` is high for one cycle per read, with only one read outstanding. In the DVSEC pass, each node is read at node+0, node+4 and node+8, in that order.
- R4: The next-node offset is bits [31:20] of the node's first dword. A value of zero ends the current pass.
- R5: In the DVSEC pass, a node matches when bits [15:0] of its second dword equal 0x1E98. Bits [15:0] of the first dword never produce this match. On a match, `dvsec_found` is set and `dvsec_off` records the node offset.
- R6: After a DVSEC match, the DOE pass restarts at 0x100 and reads only node+0. A node matches when bits [15:0] of that dword equal 0x002E. On a match, `doe_found` is set, `doe_off` records the node offset, and the walk ends.
- R7: When the DVSEC pass ends without a match, the walk ends with both found flags at 0 and no DOE pass is run.
- R8: A read error ends the walk at once with `error` and `done` both high, and no further read is issued.
- R9: Each pass visits at most MAX_HOPS (default 64) nodes. If the last allowed node still has a nonzero next offset, the walk ends with `error`. A chain of exactly MAX_HOPS nodes that ends in zero completes without error.
- R10: `done` is a one-cycle pulse. All result outputs hold their values after it until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 12 | Byte offset of the requested dword |
| rd_valid | input | 1 | Read data return strobe |
| rd_err | input | 1 | Read completed with an error |
| rd_data | input | 32 | Returned dword |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| error | output | 1 | Walk aborted (read error or hop limit) |
| dvsec_found | output | 1 | CXL DVSEC located |
| dvsec_off | output | 12 | Offset of the DVSEC node |
| doe_found | output | 1 | DOE capability located |
| doe_off | output | 12 | Offset of the DOE node |

## Verification
The start pulse is taken on edge 0. A read returned one cycle after its request costs two cycles. Each DVSEC-pass node therefore costs seven cycles: three reads plus one evaluate cycle. Each DOE-pass node costs three cycles, and a read error ends a walk two cycles after the failing request. `done` is due one cycle after the last evaluate. The bench computes that cycle count from the node list of each scenario, counts clock edges from the start pulse, samples at the falling edge and compares the count as well as the flags, the offsets and the logged read addresses.

// File: rtl/ecw_pkg.sv
package ecw_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 16;

  localparam logic [ADDR_W-1:0] LIST_BASE  = 12'h100;
  localparam logic [ID_W-1:0]   DOE_CAP_ID = 16'h002E;
  localparam logic [ID_W-1:0]   CXL_VID    = 16'h1E98;
  localparam int                NEXT_LSB   = 20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL,
    ST_FIN
  } walk_st_t;

  typedef enum logic {
    PH_DVSEC,
    PH_DOE
  } walk_ph_t;
endpackage

// File: rtl/ecw_hdr_decode.sv
module ecw_hdr_decode
  import ecw_pkg::*;
(
  input  logic [DATA_W-1:0] hdr_dw,
  input  logic [DATA_W-1:0] vend_dw,
  output logic [ADDR_W-1:0] next_off,
  output logic              is_doe,
  output logic              is_cxl
);
  logic [ID_W-1:0] cap_id;
  logic [ID_W-1:0] vend_id;

  always_comb begin
    cap_id   = hdr_dw[ID_W-1:0];
    vend_id  = vend_dw[ID_W-1:0];
    next_off = hdr_dw[NEXT_LSB +: ADDR_W];
    is_doe   = (cap_id == DOE_CAP_ID);
    is_cxl   = (vend_id == CXL_VID);
  end
endmodule

// File: rtl/ecw_hop_guard.sv
module ecw_hop_guard #(
  parameter int MAX_HOPS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic at_limit
);
  localparam int CNT_W = (MAX_HOPS > 1) ? $clog2(MAX_HOPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_HOPS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | step;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign at_limit = (cnt_q == LAST);

  // R9
  hop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |-> !at_limit);
endmodule

// File: rtl/ext_cap_walker.sv
module ext_cap_walker
  import ecw_pkg::*;
#(
  parameter int MAX_HOPS   = 64,
  parameter int HDR_DWORDS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic              rd_err,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              dvsec_found,
  output logic [ADDR_W-1:0] dvsec_off,
  output logic              doe_found,
  output logic [ADDR_W-1:0] doe_off
);
  localparam int IDX_W = (HDR_DWORDS > 1) ? $clog2(HDR_DWORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_DWORDS - 1);

  walk_st_t          st_q, st_d;
  walk_ph_t          ph_q, ph_d;
  logic [ADDR_W-1:0] node_q, node_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              err_q, err_d;
  logic              dvf_q, dvf_d;
  logic [ADDR_W-1:0] dvo_q, dvo_d;
  logic              dof_q, dof_d;
  logic [ADDR_W-1:0] doo_q, doo_d;
  logic [DATA_W-1:0] hdr_q, vend_q;
  logic              cap_we;
  logic              hop_clr, hop_step, hop_limit;
  logic [ADDR_W-1:0] nxt_off;
  logic              hit_doe, hit_cxl;

  ecw_hdr_decode u_dec (
    .hdr_dw  (hdr_q),
    .vend_dw (vend_q),
    .next_off(nxt_off),
    .is_doe  (hit_doe),
    .is_cxl  (hit_cxl)
  );

  ecw_hop_guard #(.MAX_HOPS(MAX_HOPS)) u_hop (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (hop_clr),
    .step    (hop_step),
    .at_limit(hop_limit)
  );

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    node_d   = node_q;
    idx_d    = idx_q;
    err_d    = err_q;
    dvf_d    = dvf_q;
    dvo_d    = dvo_q;
    dof_d    = dof_q;
    doo_d    = doo_q;
    hop_clr  = 1'b0;
    hop_step = 1'b0;
    cap_we   = 1'b0;
    rd_req   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_ISSUE;
          ph_d    = PH_DVSEC;
          node_d  = LIST_BASE;
          idx_d   = '0;
          err_d   = 1'b0;
          dvf_d   = 1'b0;
          dvo_d   = '0;
          dof_d   = 1'b0;
          doo_d   = '0;
          hop_clr = 1'b1;
        end
      end
      ST_ISSUE: begin
        rd_req = 1'b1;
        st_d   = ST_WAIT;
      end
      ST_WAIT: begin
        if (rd_err) begin
          err_d = 1'b1;
          st_d  = ST_FIN;
        end else if (rd_valid) begin
          cap_we = 1'b1;
          if (ph_q == PH_DVSEC && idx_q != IDX_LAST) begin
            idx_d = idx_q + 1'b1;
            st_d  = ST_ISSUE;
          end else begin
            st_d = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        idx_d = '0;
        if (ph_q == PH_DVSEC && hit_cxl) begin
          dvf_d   = 1'b1;
          dvo_d   = node_q;
          ph_d    = PH_DOE;
          node_d  = LIST_BASE;
          hop_clr = 1'b1;
          st_d    = ST_ISSUE;
        end else if (ph_q == PH_DOE && hit_doe) begin
          dof_d = 1'b1;
          doo_d = node_q;
          st_d  = ST_FIN;
        end else if (nxt_off == '0) begin
          st_d = ST_FIN;
        end else if (hop_limit) begin
          err_d = 1'b1;
          st_d  = ST_FIN;
        end else begin
          node_d   = nxt_off;
          hop_step = 1'b1;
          st_d     = ST_ISSUE;
        end
      end
      ST_FIN: begin
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_DVSEC;
      node_q <= '0;
      idx_q  <= '0;
      err_q  <= 1'b0;
      dvf_q  <= 1'b0;
      dvo_q  <= '0;
      dof_q  <= 1'b0;
      doo_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      node_q <= node_d;
      idx_q  <= idx_d;
      err_q  <= err_d;
      dvf_q  <= dvf_d;
      dvo_q  <= dvo_d;
      dof_q  <= dof_d;
      doo_q  <= doo_d;
    end
  end

  // Header capture: only the first two dwords of a node feed the decoder.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= '0;
      vend_q <= '0;
    end else if (cap_we) begin
      if (idx_q == IDX_W'(0)) hdr_q  <= rd_data;
      if (idx_q == IDX_W'(1)) vend_q <= rd_data;
    end
  end

  assign rd_addr     = node_q + {{(ADDR_W-IDX_W-2){1'b0}}, idx_q, 2'b00};
  assign busy        = (st_q != ST_IDLE);
  assign done        = (st_q == ST_FIN);
  assign error       = err_q;
  assign dvsec_found = dvf_q;
  assign dvsec_off   = dvo_q;
  assign doe_found   = dof_q;
  assign doe_off     = doo_q;

  // R3
  rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  // R6
  doe_after_dvsec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doe_found |-> dvsec_found);

  // R2
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
endmodule

// File: tb/ext_cap_walker_test.sv
module ext_cap_walker_test;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic        rd_req;
  logic [11:0] rd_addr;
  logic        rd_valid;
  logic        rd_err;
  logic [31:0] rd_data;
  logic        busy, done, error;
  logic        dvsec_found, doe_found;
  logic [11:0] dvsec_off, doe_off;

  int total = 0;
  int bad   = 0;

  logic [31:0] mem [0:1023];
  logic        pend;
  logic [11:0] paddr;
  logic        err_en;
  logic [11:0] err_addr;
  int          rd_cnt;
  logic [11:0] addr_log [0:63];

  ext_cap_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_err(rd_err), .rd_data(rd_data),
    .busy(busy), .done(done), .error(error),
    .dvsec_found(dvsec_found), .dvsec_off(dvsec_off),
    .doe_found(doe_found), .doe_off(doe_off)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Config-space model: answers one cycle after the request.
  initial begin
    pend = 1'b0; paddr = '0; rd_cnt = 0;
    rd_valid = 1'b0; rd_err = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      rd_err   = 1'b0;
      if (pend) begin
        if (err_en && paddr == err_addr) rd_err = 1'b1;
        else begin
          rd_valid = 1'b1;
          rd_data  = mem[paddr[11:2]];
        end
        pend = 1'b0;
      end
      if (rd_req) begin
        pend  = 1'b1;
        paddr = rd_addr;
        addr_log[rd_cnt % 64] = rd_addr;
        rd_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
  endtask

  task automatic put_node(input logic [11:0] a, input logic [15:0] id,
                          input logic [11:0] nxt, input logic [31:0] dw1);
    mem[a[11:2]]     = {nxt, 4'h1, id};
    mem[a[11:2] + 1] = dw1;
    mem[a[11:2] + 2] = 32'hA5A5_0000 | {20'h0, a};
  endtask

  task automatic run_walk(input int extra_at, output int lat, output int base);
    base = rd_cnt;
    lat  = 0;
    @(negedge clk);
    start = 1'b1;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = (lat == extra_at);
      if (done || lat > 5000) break;
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 error", error, 0);
    check("R1 rd_req", rd_req, 0);
    check("R1 dvsec_found", dvsec_found, 0);
    check("R1 doe_found", doe_found, 0);
    check("R1 offsets", {dvsec_off, doe_off}, 0);
  endtask

  task automatic t_basic(input int extra_at, input string tag);
    int lat, base;
    clear_mem();
    put_node(12'h100, 16'h0023, 12'h140, 32'h0000_1E98);
    put_node(12'h140, 16'h002E, 12'h000, 32'h0);
    run_walk(extra_at, lat, base);
    check({tag, " R10 latency"}, lat, 14);
    check({tag, " R5 dvsec_found"}, dvsec_found, 1);
    check({tag, " R5 dvsec_off"}, dvsec_off, 12'h100);
    check({tag, " R6 doe_found"}, doe_found, 1);
    check({tag, " R6 doe_off"}, doe_off, 12'h140);
    check({tag, " R3 read count"}, rd_cnt - base, 5);
    check({tag, " R3 addr0"}, addr_log[(base + 0) % 64], 12'h100);
    check({tag, " R3 addr1"}, addr_log[(base + 1) % 64], 12'h104);
    check({tag, " R3 addr2"}, addr_log[(base + 2) % 64], 12'h108);
    check({tag, " R6 restart addr"}, addr_log[(base + 3) % 64], 12'h100);
    check({tag, " R4 next addr"}, addr_log[(base + 4) % 64], 12'h140);
    check({tag, " R8 no error"}, error, 0);
    repeat (5) @(negedge clk);
    check({tag, " R10 done pulse"}, done, 0);
    check({tag, " R10 hold"}, {dvsec_found, doe_found, dvsec_off, doe_off}, {2'b11, 12'h100, 12'h140});
    check({tag, " R10 idle"}, busy, 0);
  endtask

  task automatic t_restart();
    int lat, base;
    clear_mem();
    put_node(12'h100, 16'h0001, 12'h180, 32'h0000_0001);
    put_node(12'h180, 16'h002E, 12'h200, 32'h0);
    put_node(12'h200, 16'h0023, 12'h000, 32'h0000_1E98);
    run_walk(0, lat, base);
    check("R6 restart latency", lat, 28);
    check("R5 deep dvsec_off", dvsec_off, 12'h200);
    check("R6 doe before dvsec", doe_off, 12'h180);
    check("R6 doe_found", doe_found, 1);
    check("R6 read count", rd_cnt - base, 11);
    check("R6 restart at base", addr_log[(base + 9) % 64], 12'h100);
  endtask

  task automatic t_no_dvsec();
    int lat, base;
    clear_mem();
    put_node(12'h100, 16'h1E98, 12'h150, 32'h1E98_002E);
    put_node(12'h150, 16'h002E, 12'h000, 32'h0);
    run_walk(0, lat, base);
    check("R7 latency", lat, 15);
    check("R5 decoy ignored", dvsec_found, 0);
    check("R7 no doe search", doe_found, 0);
    check("R7 read count", rd_cnt - base, 6);
    check("R7 no error", error, 0);
  endtask

  task automatic t_no_doe();
    int lat, base;
    clear_mem();
    put_node(12'h100, 16'h0023, 12'h000, 32'h0000_1E98);
    run_walk(0, lat, base);
    check("R4 latency", lat, 11);
    check("R4 dvsec_found", dvsec_found, 1);
    check("R4 doe absent", doe_found, 0);
    check("R4 read count", rd_cnt - base, 4);
  endtask

  task automatic t_rd_error();
    int lat, base;
    clear_mem();
    put_node(12'h100, 16'h0023, 12'h140, 32'h0000_1E98);
    put_node(12'h140, 16'h002E, 12'h000, 32'h0);
    err_addr = 12'h104;
    err_en   = 1'b1;
    run_walk(0, lat, base);
    check("R8 latency", lat, 5);
    check("R8 error", error, 1);
    check("R8 done", done, 1);
    check("R8 dvsec not set", dvsec_found, 0);
    repeat (10) @(negedge clk);
    check("R8 no more reads", rd_cnt - base, 2);
    err_en = 1'b0;
  endtask

  task automatic t_loop();
    int lat, base;
    clear_mem();
    put_node(12'h100, 16'h0007, 12'h100, 32'h0);
    run_walk(0, lat, base);
    check("R9 loop latency", lat, 449);
    check("R9 loop error", error, 1);
    check("R9 loop reads", rd_cnt - base, 192);
  endtask

  task automatic t_long_chain();
    int lat, base;
    clear_mem();
    for (int i = 0; i < 64; i++)
      put_node(12'(12'h100 + 16 * i), 16'h0005, (i < 63) ? 12'(12'h110 + 16 * i) : 12'h000, 32'h0);
    run_walk(0, lat, base);
    check("R9 64-node latency", lat, 449);
    check("R9 64-node no error", error, 0);
    check("R9 64-node dvsec", dvsec_found, 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    err_en   = 1'b0;
    err_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic(0, "basic");
    t_restart();
    t_no_dvsec();
    t_no_doe();
    t_rd_error();
    t_loop();
    t_long_chain();
    // R2: a second start while busy changes nothing
    t_basic(5, "R2 busy start");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule